// File: doc/BRIEF.md
# Configuration Image Byte Loader

This block pushes a configuration image into the byte-wide programming port of a downstream programmable device. A host pulses `start_i`. The loader then does the following, in order:

- It drives a reset pulse toward the target for a fixed number of cycles.
- It writes a single zero pad byte.
- It reads the image from a valid/ready byte stream. The first 16 bytes of the image are a header, and the payload length is taken from its first four bytes.
- It copies exactly that many payload bytes onto the port, one write strobe per byte.
- It appends five zero pad bytes.
- It samples the error line of the target.

The device interrupt enable stays low for the whole sequence. A clean load re-enables it after a programmable settling wait and raises `done_o`. An error raises `fail_o` and leaves the interrupt enable low.

Top module: `cfg_image_loader`

## Requirements
- R1: A start pulse while idle makes `busy_o` high from the next cycle. In that same cycle `done_o`, `fail_o` and `irq_en_o` go low, and `tgt_rst_o` is then high for exactly RST_CYCLES consecutive cycles.
- R2: In the cycle right after the reset pulse, exactly one write strobe is issued with data 0x00, and `in_ready_o` is low.
- R3: The next 16 accepted stream bytes are the header, and `in_ready_o` is high while it is read. Bytes 0..3 form the payload length as a 32-bit big-endian value, with byte 0 as the most significant. Bytes 4..15 are discarded and produce no write strobe.
- R4: After the header, exactly the header length in bytes is accepted. Each byte appears unchanged on `prog_data_o`, with `prog_we_o` high, in the cycle it is accepted, and the bytes keep their stream order.
- R5: A length of zero goes directly from the last header byte to the trailing pads, and no payload byte is accepted.
- R6: The payload is followed by five consecutive write strobes with data 0x00, and `in_ready_o` stays low during them.
- R7: `tgt_err_i` is sampled in the cycle after the last trailing pad. If it is high, `fail_o` is set, `irq_en_o` stays low and `busy_o` falls in the next cycle.
- R8: If `tgt_err_i` is low at the sample point, a wait of SETTLE_CYCLES cycles follows. Then `irq_en_o` and `done_o` rise together and `busy_o` falls. `irq_en_o` is never high while busy.
- R9: A start pulse while `busy_o` is high has no effect on any output.
- R10: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse from the host |
| in_data_i | input | 8 | Image byte stream data |
| in_valid_i | input | 1 | Image byte valid |
| in_ready_o | output | 1 | Loader accepts an image byte |
| tgt_rst_o | output | 1 | Reset pulse toward the target device |
| prog_data_o | output | 8 | Programming port data |
| prog_we_o | output | 1 | Programming port write strobe |
| tgt_err_i | input | 1 | Error line from the target |
| irq_en_o | output | 1 | Device interrupt enable |
| busy_o | output | 1 | Load sequence in progress |
| done_o | output | 1 | Last load succeeded |
| fail_o | output | 1 | Last load failed |

## Verification
The assertions assume that the stream supplies at least as many bytes as the header announces, and that a run is never cut short by reset. The bench builds every image with exactly 16 plus length bytes and inserts random idle gaps on the valid line. It holds `tgt_err_i` constant for a whole run, so the sample point sees a defined level. Extra start pulses are injected only while a run is in flight, so that R9 is exercised without breaking these input assumptions.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_LEAD, ST_HDR, ST_DATA, ST_TAIL, ST_CHK, ST_SETTLE
  } ld_state_e;
endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  p_no_underflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser #(
  parameter int HDR_BYTES = 16,
  parameter int LEN_BYTES = 4,
  localparam int LEN_W    = 8 * LEN_BYTES,
  localparam int IDX_W    = $clog2(HDR_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             beat_i,
  input  logic [7:0]       data_i,
  output logic             last_o,
  output logic [LEN_W-1:0] len_o
);
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (beat_i) begin
      idx_q <= idx_q + 1'b1;
      // big-endian: earlier byte shifts up
      if (idx_q < IDX_W'(LEN_BYTES)) len_q <= {len_q[LEN_W-9:0], data_i};
    end
  end

  assign last_o = (idx_q == IDX_W'(HDR_BYTES - 1));
  assign len_o  = len_q;

  p_len_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !clr_i && idx_q >= IDX_W'(LEN_BYTES)) |=> $stable(len_o));
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfg_loader_pkg::*;
#(
  parameter int RST_CYCLES    = 4,
  parameter int SETTLE_CYCLES = 6,
  parameter int HDR_BYTES     = 16,
  parameter int LEN_BYTES     = 4,
  parameter int TAIL_PADS     = 5,
  parameter int CNT_W         = 16,
  localparam int LEN_W        = 8 * LEN_BYTES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  output logic       tgt_rst_o,
  output logic [7:0] prog_data_o,
  output logic       prog_we_o,
  input  logic       tgt_err_i,
  output logic       irq_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o
);
  ld_state_e        state_q, state_d;
  logic [LEN_W-1:0] rem_q, hdr_len;
  logic             tmr_load, tmr_exp, hdr_last, beat, hdr_beat, kick;
  logic [CNT_W-1:0] tmr_val;
  logic             done_q, fail_q, irq_q;

  assign in_ready_o = (state_q == ST_HDR) || (state_q == ST_DATA);
  assign beat       = in_valid_i && in_ready_o;
  assign hdr_beat   = beat && (state_q == ST_HDR);
  assign kick       = (state_q == ST_IDLE) && start_i;

  cfg_hdr_parser #(.HDR_BYTES(HDR_BYTES), .LEN_BYTES(LEN_BYTES)) u_hdr (
    .clk_i, .rst_ni, .clr_i(kick), .beat_i(hdr_beat), .data_i(in_data_i),
    .last_o(hdr_last), .len_o(hdr_len)
  );

  cfg_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .expire_o(tmr_exp)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RST; tmr_load = 1'b1; tmr_val = CNT_W'(RST_CYCLES - 1);
      end
      ST_RST:  if (tmr_exp) state_d = ST_LEAD;
      ST_LEAD: state_d = ST_HDR;
      ST_HDR:  if (hdr_beat && hdr_last) begin
        if (hdr_len == '0) begin
          state_d = ST_TAIL; tmr_load = 1'b1; tmr_val = CNT_W'(TAIL_PADS - 1);
        end else state_d = ST_DATA;
      end
      ST_DATA: if (beat && rem_q == LEN_W'(1)) begin
        state_d = ST_TAIL; tmr_load = 1'b1; tmr_val = CNT_W'(TAIL_PADS - 1);
      end
      ST_TAIL: if (tmr_exp) state_d = ST_CHK;
      ST_CHK:  if (tgt_err_i) state_d = ST_IDLE;
               else begin
                 state_d = ST_SETTLE; tmr_load = 1'b1;
                 tmr_val = CNT_W'(SETTLE_CYCLES - 1);
               end
      ST_SETTLE: if (tmr_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hdr_beat && hdr_last)                rem_q <= hdr_len;
      else if (beat && state_q == ST_DATA)     rem_q <= rem_q - 1'b1;
      if (kick) begin
        done_q <= 1'b0; fail_q <= 1'b0; irq_q <= 1'b0;
      end else if (state_q == ST_CHK && tgt_err_i) begin
        fail_q <= 1'b1;
      end else if (state_q == ST_SETTLE && tmr_exp) begin
        done_q <= 1'b1; irq_q <= 1'b1;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign tgt_rst_o   = (state_q == ST_RST);
  assign prog_we_o   = (state_q == ST_LEAD) || (state_q == ST_TAIL) ||
                       (beat && state_q == ST_DATA);
  assign prog_data_o = (state_q == ST_DATA) ? in_data_i : 8'h00;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign irq_en_o    = irq_q;

  p_start_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && tgt_rst_o && !done_o && !fail_o && !irq_en_o));
  p_lead_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_rst_o) |-> (prog_we_o && prog_data_o == 8'h00 && !in_ready_o));
  p_pad_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we_o && !in_ready_o) |-> (prog_data_o == 8'h00));
  p_fail_no_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (!irq_en_o && !busy_o));
  p_irq_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_en_o);
  p_status_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tgt_rst_o) |=> !tgt_rst_o);
endmodule

// File: tb/cfg_image_loader_bench.sv
`timescale 1ns/1ps
module cfg_image_loader_bench;
  localparam int RST_C = 4, SET_C = 6, PADS = 5;

  logic clk = 0, rst_ni = 0, start_i = 0, in_valid_i = 0, tgt_err_i = 0;
  logic [7:0] in_data_i = 0;
  logic in_ready_o, tgt_rst_o, prog_we_o, irq_en_o, busy_o, done_o, fail_o;
  logic [7:0] prog_data_o;

  cfg_image_loader #(.RST_CYCLES(RST_C), .SETTLE_CYCLES(SET_C)) u_cfg_image_loader (
    .clk_i(clk), .rst_ni, .start_i, .in_data_i, .in_valid_i, .in_ready_o,
    .tgt_rst_o, .prog_data_o, .prog_we_o, .tgt_err_i, .irq_en_o, .busy_o,
    .done_o, .fail_o);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] img[$];
  logic [7:0] got[$];
  bit dense = 0;
  int rst_seen = 0;

  // behavioural reference: phase 0 idle,1 reset,2 lead,3 header,4 payload,5 tail,6 check,7 settle
  int ph = 0, k = 0, hb = 0;
  longint unsigned mlen = 0;
  bit m_irq = 0, m_done = 0, m_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_ni) begin
      bit acc;
      acc = in_valid_i && (ph == 3 || ph == 4);
      if (acc) void'(img.pop_front());
      case (ph)
        0: if (start_i) begin ph = 1; k = 0; m_irq = 0; m_done = 0; m_fail = 0; end
        1: begin k++; if (k == RST_C) ph = 2; end
        2: begin ph = 3; hb = 0; mlen = 0; end
        3: if (acc) begin
             if (hb < 4) mlen = (mlen << 8) | in_data_i;
             hb++;
             if (hb == 16) begin ph = (mlen == 0) ? 5 : 4; k = 0; end
           end
        4: if (acc) begin mlen--; if (mlen == 0) begin ph = 5; k = 0; end end
        5: begin k++; if (k == PADS) ph = 6; end
        6: if (tgt_err_i) begin m_fail = 1; ph = 0; end else begin ph = 7; k = 0; end
        7: begin k++; if (k == SET_C) begin ph = 0; m_irq = 1; m_done = 1; end end
        default: ph = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (img.size() > 0 && (dense || ($urandom % 3) != 0)) begin
      in_valid_i = 1; in_data_i = img[0];
    end else begin
      in_valid_i = 0; in_data_i = 8'($urandom);
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      bit e_rdy, e_we;
      e_rdy = (ph == 3 || ph == 4);
      e_we  = (ph == 2 || ph == 5 || (ph == 4 && in_valid_i));
      chk(busy_o == (ph != 0), "R1", "busy", busy_o, ph != 0);
      chk(tgt_rst_o == (ph == 1), "R1", "tgt_rst", tgt_rst_o, ph == 1);
      chk(in_ready_o == e_rdy, "R3", "in_ready", in_ready_o, e_rdy);
      chk(prog_we_o == e_we, "R4", "prog_we", prog_we_o, e_we);
      if (e_we) chk(prog_data_o == ((ph == 4) ? in_data_i : 8'h00), "R4", "prog_data",
                    prog_data_o, (ph == 4) ? in_data_i : 8'h00);
      chk(irq_en_o == m_irq, "R8", "irq_en", irq_en_o, m_irq);
      chk(done_o == m_done, "R8", "done", done_o, m_done);
      chk(fail_o == m_fail, "R7", "fail", fail_o, m_fail);
      if (prog_we_o) got.push_back(prog_data_o);
      if (tgt_rst_o) rst_seen++;
    end
  end

  task automatic run_image(input int len, input bit err, input bit dn, input bit poke);
    logic [7:0] exp_w[$];
    int n;
    got.delete(); rst_seen = 0; dense = dn; tgt_err_i = err;
    img.delete();
    img.push_back(8'(len >> 24)); img.push_back(8'(len >> 16));
    img.push_back(8'(len >> 8));  img.push_back(8'(len));
    for (int i = 4; i < 16; i++) img.push_back(8'($urandom | 1));
    exp_w.push_back(8'h00);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b; b = 8'($urandom); img.push_back(b); exp_w.push_back(b);
    end
    for (int i = 0; i < PADS; i++) exp_w.push_back(8'h00);
    @(posedge clk); #1 start_i = 1;
    @(posedge clk); #1 start_i = 0;
    n = 0;
    while (ph != 0 && n < 5000) begin
      @(posedge clk); n++;
      if (poke && (n % 7) == 3) begin #1 start_i = 1; @(posedge clk); #1 start_i = 0; n++; end
    end
    @(negedge clk);
    chk(rst_seen == RST_C, "R1", "reset pulse length", rst_seen, RST_C);
    chk(got.size() == exp_w.size(), "R4", "write count", got.size(), exp_w.size());
    for (int i = 0; i < exp_w.size() && i < got.size(); i++)
      chk(got[i] == exp_w[i], (i == 0) ? "R2" : (i > len) ? "R6" : "R4", "written byte",
          got[i], exp_w[i]);
    chk(img.size() == 0, len == 0 ? "R5" : "R3", "bytes left in stream", img.size(), 0);
    chk(busy_o == 0, "R8", "busy after run", busy_o, 0);
    chk(err ? (fail_o && !irq_en_o && !done_o) : (done_o && irq_en_o && !fail_o),
        err ? "R7" : "R8", "final status", {done_o, fail_o, irq_en_o}, err ? 3'b010 : 3'b101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({in_ready_o, tgt_rst_o, prog_we_o, irq_en_o, busy_o, done_o, fail_o} == 0,
        "R10", "outputs in reset", {in_ready_o, tgt_rst_o, prog_we_o, irq_en_o, busy_o, done_o, fail_o}, 0);
    @(posedge clk); #1 rst_ni = 1;
    run_image(5, 0, 0, 1);   // R9 extra starts while busy
    run_image(0, 0, 0, 0);   // R5
    run_image(3, 1, 1, 0);   // R7
    run_image(20, 0, 1, 1);  // R4 dense stream, R9
    run_image(1, 1, 0, 0);   // R7
    run_image(260, 0, 0, 0); // R3 length needs two bytes
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule